// File: doc/BRIEF.md
# Flash Maintenance Sequencer

This block drives a serial flash through a quad-lane command engine to run maintenance jobs: erasing the whole array, erasing one sector, and programming a run of bytes taken from a data FIFO. Every job is a fixed chain. First a write-enable command goes out. Then the job's own command follows. Then the status word is read again and again until the flash says it is idle. Last, the engine is set back to memory-mapped fast read, so the processor can fetch from flash again.

Program jobs are broken into page commands so that no single command crosses a 256-byte address boundary. Each page gets its own write-enable and its own busy wait. A separate init job moves the flash into four-lane command mode. The flash only accepts single-lane commands out of reset, so that switch command always goes out on one lane. Every later command uses four lanes.

The engine sits behind a request/acknowledge handshake. The sequencer holds a command descriptor steady while the request is up. The engine answers with a one-cycle acknowledge, and for a status read it returns the status word on the same cycle as that acknowledge.

Top module: `flash_maint_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy`, `done`, `error` and `eng_req` are all 0.
- R2: Each erase or program command is issued straight after an acknowledged write-enable (opcode 0x06, no address, single or current lane mode).
- R3: After the job command, read-status (opcode 0x05, kind read = 1, length 2) is reissued until a returned word has bit 0 clear. Bits 15..1 of the word have no effect.
- R4: Each job ends with a memory-mapped fast-read setup: opcode 0x0B, kind = 2, address present with value 0, length 0, 8 dummy cycles. `done` pulses for one cycle in the cycle after its acknowledge, and `busy` is 0 in that cycle.
- R5: A program job of N bytes at address A is sent as page-program commands (opcode 0x02, with address). The first command ends at the next 256-byte boundary, and no command exceeds 256 bytes or crosses a boundary. Each command has its own write-enable and status poll. N = 0 sends only the R4 restore.
- R6: The init job (op 3) sends opcode 0x38 with lane code 0 (single). Every command before init uses lane code 0, and every command after it uses lane code 2 (quad).
- R7: If POLL_MAX status reads in a row return busy, polling stops. The R4 restore is still sent, and `error` pulses together with `done`. The next job starts with the error cleared.
- R8: A `start` pulse while `busy` is 1 has no effect: no extra commands are issued and the running job's address and opcode are unchanged.
- R9: While `eng_req` is 1 and `eng_ack` is 0, the request and every descriptor field hold their values into the next cycle.
- R10: Op code 0 (chip erase) sends opcode 0xC7 with no address. Op code 1 (sector erase) sends opcode 0x20 with the latched address. Op code 2 is program.
- R11: `fifo_rd` follows `eng_wtake` only while a page-program command is being requested, and stays 0 during every other command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the selected job when idle |
| op_sel | input | 2 | Job: 0 chip erase, 1 sector erase, 2 program, 3 init |
| op_addr | input | ADDR_W | Flash byte address of the job |
| op_len | input | LEN_W | Number of bytes to program |
| fifo_data | input | 8 | Head byte of the program-data FIFO |
| fifo_rd | output | 1 | Pop the program-data FIFO |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse when a job finishes |
| error | output | 1 | Pulses with done when polling timed out |
| eng_req | output | 1 | Command request to the engine |
| eng_ack | input | 1 | Engine accepted and finished the command |
| eng_opcode | output | 8 | Command opcode |
| eng_lanes | output | 2 | Lane code: 0 single, 2 quad |
| eng_kind | output | 2 | 0 write, 1 read, 2 memory-mapped |
| eng_has_addr | output | 1 | Address phase present |
| eng_addr | output | ADDR_W | Address phase value |
| eng_len | output | CHUNK_W | Data bytes of the command |
| eng_dummy | output | 5 | Dummy cycles |
| eng_wdata | output | 8 | Program byte to the engine |
| eng_wtake | input | 1 | Engine consumes a program byte |
| eng_rdata | input | 16 | Status word returned with the acknowledge |

## Verification
On every cycle the assertions check that a pending request and its descriptor hold still, that each job command follows an acknowledged write-enable, that no page command crosses a boundary, that the lane switch stays single-lane, that the restore always carries fast read with 8 dummy cycles, and that the poll count never passes its limit. Several properties need the bench's scenarios instead: the exact order of commands across a whole job, the page split of an unaligned program, lane codes before and after init, that status bits other than bit 0 are ignored, the timeout error, and a start pulse that arrives mid-job.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int ADDR_W     = 24;
    localparam int PAGE_BYTES = 256;
    localparam int PAGE_AW    = $clog2(PAGE_BYTES);
    localparam int CHUNK_W    = PAGE_AW + 1;
    localparam int STAT_W     = 16;
    localparam int BUSY_BIT   = 0;
    localparam int MMAP_DUMMY = 8;
    localparam int STAT_BYTES = 2;

    localparam logic [STAT_W-1:0] STAT_BUSY_MASK = STAT_W'(1) << BUSY_BIT;

    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_CHIP  = 8'hC7;
    localparam logic [7:0] OPC_SECT  = 8'h20;
    localparam logic [7:0] OPC_PROG  = 8'h02;
    localparam logic [7:0] OPC_RDSR  = 8'h05;
    localparam logic [7:0] OPC_FREAD = 8'h0B;
    localparam logic [7:0] OPC_QEN   = 8'h38;

    typedef enum logic [1:0] {
        OP_CHIP_ERASE = 2'd0,
        OP_SECT_ERASE = 2'd1,
        OP_PROGRAM    = 2'd2,
        OP_INIT       = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        LANE_SINGLE = 2'd0,
        LANE_DUAL   = 2'd1,
        LANE_QUAD   = 2'd2
    } lane_e;

    typedef enum logic [1:0] {
        KIND_WRITE = 2'd0,
        KIND_READ  = 2'd1,
        KIND_MMAP  = 2'd2
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QEN,
        ST_WREN,
        ST_OPER,
        ST_POLL,
        ST_MMAP
    } st_e;

    typedef struct packed {
        logic [7:0]         opcode;
        lane_e              lanes;
        kind_e              kind;
        logic               has_addr;
        logic [ADDR_W-1:0]  addr;
        logic [CHUNK_W-1:0] len;
        logic [4:0]         dummy;
    } cmd_t;

    function automatic logic [CHUNK_W-1:0] page_room(input logic [PAGE_AW-1:0] off);
        return CHUNK_W'(PAGE_BYTES) - CHUNK_W'(off);
    endfunction

endpackage

// File: rtl/flash_page_split.sv
module flash_page_split
    import flash_seq_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [PAGE_AW-1:0] page_off,
    input  logic [LEN_W-1:0]   remain,
    output logic [CHUNK_W-1:0] chunk
);
    logic [CHUNK_W-1:0] room;

    always_comb begin
        room = page_room(page_off);
        if (remain < LEN_W'(room))
            chunk = CHUNK_W'(remain);
        else
            chunk = room;
    end

endmodule

// File: rtl/flash_poll_limit.sv
module flash_poll_limit #(
    parameter int POLL_MAX = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic hit,
    output logic last
);
    localparam int CW = $clog2(POLL_MAX + 1);

    logic [CW-1:0] cnt;

    assign last = (cnt == CW'(POLL_MAX - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (hit && !last)
            cnt <= cnt + CW'(1);
    end

    p_poll_cap_r7: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(POLL_MAX - 1))
        else $error("poll counter past limit");

endmodule

// File: rtl/flash_cmd_build.sv
module flash_cmd_build
    import flash_seq_pkg::*;
(
    input  st_e                st,
    input  op_e                op,
    input  logic               quad_on,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CHUNK_W-1:0] chunk,
    output cmd_t               cmd
);
    always_comb begin
        cmd          = '0;
        cmd.lanes    = (st == ST_QEN || !quad_on) ? LANE_SINGLE : LANE_QUAD;
        cmd.kind     = KIND_WRITE;
        unique case (st)
            ST_QEN:  cmd.opcode = OPC_QEN;
            ST_WREN: cmd.opcode = OPC_WREN;
            ST_OPER: begin
                case (op)
                    OP_SECT_ERASE: begin
                        cmd.opcode   = OPC_SECT;
                        cmd.has_addr = 1'b1;
                        cmd.addr     = addr;
                    end
                    OP_PROGRAM: begin
                        cmd.opcode   = OPC_PROG;
                        cmd.has_addr = 1'b1;
                        cmd.addr     = addr;
                        cmd.len      = chunk;
                    end
                    default: cmd.opcode = OPC_CHIP;
                endcase
            end
            ST_POLL: begin
                cmd.opcode = OPC_RDSR;
                cmd.kind   = KIND_READ;
                cmd.len    = CHUNK_W'(STAT_BYTES);
            end
            ST_MMAP: begin
                cmd.opcode   = OPC_FREAD;
                cmd.kind     = KIND_MMAP;
                cmd.has_addr = 1'b1;
                cmd.dummy    = 5'(MMAP_DUMMY);
            end
            default: cmd.opcode = 8'h00;
        endcase
    end

endmodule

// File: rtl/flash_maint_seq.sv
module flash_maint_seq
    import flash_seq_pkg::*;
#(
    parameter int LEN_W        = 16,
    parameter int POLL_MAX     = 4096,
    parameter bit QUAD_DEFAULT = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [1:0]         op_sel,
    input  logic [ADDR_W-1:0]  op_addr,
    input  logic [LEN_W-1:0]   op_len,
    input  logic [7:0]         fifo_data,
    output logic               fifo_rd,
    output logic               busy,
    output logic               done,
    output logic               error,
    output logic               eng_req,
    input  logic               eng_ack,
    output logic [7:0]         eng_opcode,
    output logic [1:0]         eng_lanes,
    output logic [1:0]         eng_kind,
    output logic               eng_has_addr,
    output logic [ADDR_W-1:0]  eng_addr,
    output logic [CHUNK_W-1:0] eng_len,
    output logic [4:0]         eng_dummy,
    output logic [7:0]         eng_wdata,
    input  logic               eng_wtake,
    input  logic [STAT_W-1:0]  eng_rdata
);
    st_e                st;
    op_e                cur_op;
    logic [ADDR_W-1:0]  cur_addr;
    logic [LEN_W-1:0]   remain;
    logic               quad_on;
    logic               err_flag;
    logic [CHUNK_W-1:0] chunk;
    logic               poll_last;
    logic               flash_busy;
    cmd_t               cmd;
    op_e                req_op;

    assign req_op     = op_e'(op_sel);
    assign flash_busy = |(eng_rdata & STAT_BUSY_MASK);
    assign busy       = (st != ST_IDLE);
    assign eng_req    = busy;

    flash_page_split #(.LEN_W(LEN_W)) u_split (
        .page_off (cur_addr[PAGE_AW-1:0]),
        .remain   (remain),
        .chunk    (chunk)
    );

    flash_poll_limit #(.POLL_MAX(POLL_MAX)) u_poll (
        .clk  (clk),
        .rst  (rst),
        .clr  (st == ST_OPER && eng_ack),
        .hit  (st == ST_POLL && eng_ack && flash_busy),
        .last (poll_last)
    );

    flash_cmd_build u_build (
        .st      (st),
        .op      (cur_op),
        .quad_on (quad_on),
        .addr    (cur_addr),
        .chunk   (chunk),
        .cmd     (cmd)
    );

    assign eng_opcode   = cmd.opcode;
    assign eng_lanes    = cmd.lanes;
    assign eng_kind     = cmd.kind;
    assign eng_has_addr = cmd.has_addr;
    assign eng_addr     = cmd.addr;
    assign eng_len      = cmd.len;
    assign eng_dummy    = cmd.dummy;
    assign eng_wdata    = fifo_data;
    assign fifo_rd      = eng_wtake && (st == ST_OPER) && (cur_op == OP_PROGRAM);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cur_op   <= OP_CHIP_ERASE;
            cur_addr <= '0;
            remain   <= '0;
            quad_on  <= 1'b0;
            err_flag <= 1'b0;
            done     <= 1'b0;
            error    <= 1'b0;
        end else begin
            done  <= 1'b0;
            error <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    cur_op   <= req_op;
                    cur_addr <= op_addr;
                    remain   <= op_len;
                    err_flag <= 1'b0;
                    if (req_op == OP_INIT)
                        st <= QUAD_DEFAULT ? ST_QEN : ST_MMAP;
                    else if (req_op == OP_PROGRAM && op_len == '0)
                        st <= ST_MMAP;
                    else
                        st <= ST_WREN;
                end
                ST_QEN: if (eng_ack) begin
                    quad_on <= 1'b1;
                    st      <= ST_MMAP;
                end
                ST_WREN: if (eng_ack) st <= ST_OPER;
                ST_OPER: if (eng_ack) begin
                    if (cur_op == OP_PROGRAM) begin
                        cur_addr <= cur_addr + ADDR_W'(chunk);
                        remain   <= remain - LEN_W'(chunk);
                    end
                    st <= ST_POLL;
                end
                ST_POLL: if (eng_ack) begin
                    if (!flash_busy)
                        st <= (cur_op == OP_PROGRAM && remain != '0) ? ST_WREN : ST_MMAP;
                    else if (poll_last) begin
                        err_flag <= 1'b1;
                        st       <= ST_MMAP;
                    end
                end
                ST_MMAP: if (eng_ack) begin
                    done  <= 1'b1;
                    error <= err_flag;
                    st    <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Checker state: set by an acknowledged write-enable, cleared by any other acknowledge.
    logic wren_armed;
    always_ff @(posedge clk) begin
        if (rst)
            wren_armed <= 1'b0;
        else if (eng_req && eng_ack)
            wren_armed <= (eng_opcode == OPC_WREN);
    end

    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (eng_req && !eng_ack) |=> (eng_req && $stable(eng_opcode) && $stable(eng_addr)
                                   && $stable(eng_len) && $stable(eng_lanes)))
        else $error("request dropped or descriptor changed before ack");

    p_wren_first_r2: assert property (@(posedge clk) disable iff (rst)
        (eng_req && (eng_opcode == OPC_CHIP || eng_opcode == OPC_SECT || eng_opcode == OPC_PROG))
            |-> wren_armed)
        else $error("job command without preceding write-enable");

    p_page_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (eng_req && eng_opcode == OPC_PROG) |->
            (eng_len != '0 && (int'(eng_addr[PAGE_AW-1:0]) + int'(eng_len) <= PAGE_BYTES)))
        else $error("page command crosses boundary");

    p_qen_single_r6: assert property (@(posedge clk) disable iff (rst)
        (eng_req && eng_opcode == OPC_QEN) |-> (eng_lanes == LANE_SINGLE))
        else $error("lane switch not sent on one lane");

    p_mmap_setup_r4: assert property (@(posedge clk) disable iff (rst)
        (eng_req && eng_kind == KIND_MMAP) |->
            (eng_opcode == OPC_FREAD && eng_dummy == 5'(MMAP_DUMMY)))
        else $error("restore is not fast read with 8 dummies");

    p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)))
        else $error("done without finishing a job");

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(cur_op))
        else $error("start accepted while busy");

endmodule

// File: tb/flash_maint_seq_test.sv
`timescale 1ns/1ps
module flash_maint_seq_test;
    localparam int LEN_W    = 16;
    localparam int POLL_MAX = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op_sel = 2'd0;
    logic [23:0] op_addr = '0;
    logic [15:0] op_len = '0;
    logic [7:0]  fifo_data = 8'hA5;
    logic        fifo_rd;
    logic        busy, done, error;
    logic        eng_req;
    logic        eng_ack;
    logic [7:0]  eng_opcode;
    logic [1:0]  eng_lanes, eng_kind;
    logic        eng_has_addr;
    logic [23:0] eng_addr;
    logic [8:0]  eng_len;
    logic [4:0]  eng_dummy;
    logic [7:0]  eng_wdata;
    logic        eng_wtake;
    logic [15:0] eng_rdata;

    always #2 clk = ~clk;

    flash_maint_seq #(.LEN_W(LEN_W), .POLL_MAX(POLL_MAX), .QUAD_DEFAULT(1'b1)) uut (
        .clk(clk), .rst(rst), .start(start), .op_sel(op_sel), .op_addr(op_addr),
        .op_len(op_len), .fifo_data(fifo_data), .fifo_rd(fifo_rd), .busy(busy),
        .done(done), .error(error), .eng_req(eng_req), .eng_ack(eng_ack),
        .eng_opcode(eng_opcode), .eng_lanes(eng_lanes), .eng_kind(eng_kind),
        .eng_has_addr(eng_has_addr), .eng_addr(eng_addr), .eng_len(eng_len),
        .eng_dummy(eng_dummy), .eng_wdata(eng_wdata), .eng_wtake(eng_wtake),
        .eng_rdata(eng_rdata)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [7:0]  op;
        logic [1:0]  lanes;
        logic [1:0]  kind;
        logic        ha;
        logic [23:0] addr;
        logic [8:0]  len;
        logic [4:0]  dummy;
    } exp_t;

    exp_t exp_q[$];
    int   busy_q[$];
    int   cur_busy = -1;

    task automatic push(input logic [7:0] op, input logic [1:0] lanes, input logic [1:0] kind,
                        input logic ha, input logic [23:0] addr, input logic [8:0] len,
                        input logic [4:0] dummy);
        exp_t e;
        e = '{op, lanes, kind, ha, addr, len, dummy};
        exp_q.push_back(e);
    endtask

    task automatic push_wren(input logic [1:0] l);  push(8'h06, l, 2'd0, 1'b0, 24'h0, 9'd0, 5'd0); endtask
    task automatic push_rdsr(input logic [1:0] l);  push(8'h05, l, 2'd1, 1'b0, 24'h0, 9'd2, 5'd0); endtask
    task automatic push_mmap(input logic [1:0] l);  push(8'h0B, l, 2'd2, 1'b1, 24'h0, 9'd0, 5'd8); endtask

    function automatic string req_of(input logic [7:0] op);
        case (op)
            8'h06:        return "R2";
            8'h05:        return "R3";
            8'h0B:        return "R4";
            8'h02:        return "R5";
            8'h38:        return "R6";
            default:      return "R10";
        endcase
    endfunction

    // Behavioural engine: one cycle to consume a byte, one to acknowledge.
    int   phase = 0;
    exp_t held;
    always @(negedge clk) begin
        if (rst) begin
            eng_ack   = 1'b0;
            eng_wtake = 1'b0;
            eng_rdata = 16'h0;
            phase     = 0;
        end else if (eng_ack) begin
            eng_ack = 1'b0;
            phase   = 0;
        end else if (eng_req) begin
            if (phase == 0) begin
                held = '{eng_opcode, eng_lanes, eng_kind, eng_has_addr, eng_addr, eng_len, eng_dummy};
                eng_wtake = 1'b1;
                #1;
                check(fifo_rd == (eng_opcode == 8'h02), "R11", "fifo pop",
                      64'(fifo_rd), 64'(eng_opcode == 8'h02));
                eng_wtake = 1'b0;
                phase = 1;
            end else begin
                exp_t got;
                got = '{eng_opcode, eng_lanes, eng_kind, eng_has_addr, eng_addr, eng_len, eng_dummy};
                check(got == held, "R9", "descriptor held", 64'(got), 64'(held));
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected command", 64'(got), 64'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(got == e, req_of(e.op), "command", 64'(got), 64'(e));
                end
                if (eng_opcode == 8'h05) begin
                    if (cur_busy < 0) cur_busy = (busy_q.size() != 0) ? busy_q.pop_front() : 0;
                    if (cur_busy > 0) begin
                        eng_rdata = 16'h5A5B;
                        cur_busy--;
                    end else begin
                        eng_rdata = 16'hFFFE;
                        cur_busy  = -1;
                    end
                end else begin
                    eng_rdata = 16'h0001;
                end
                eng_ack = 1'b1;
            end
        end
    end

    task automatic run_op(input logic [1:0] op, input logic [23:0] a, input logic [15:0] len,
                          input bit exp_err, input bit poke, input string tag);
        int n;
        cur_busy = -1;
        @(negedge clk);
        op_sel = op; op_addr = a; op_len = len; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, tag, "busy after start", 64'(busy), 64'h1);
        if (poke) begin
            repeat (4) @(negedge clk);
            op_sel = 2'd0; op_addr = 24'hABCDEF; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, tag, "job finished", 64'(done), 64'h1);
        check(error == exp_err, "R7", "error flag with done", 64'(error), 64'(exp_err));
        check(busy == 1'b0, "R4", "idle at done", 64'(busy), 64'h0);
        check(exp_q.size() == 0, "R4", "commands left unsent", 64'(exp_q.size()), 64'h0);
        exp_q.delete();
        busy_q.delete();
        repeat (3) @(negedge clk);
        check(!busy && !done, "R8", "no further job", 64'({busy, done}), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({busy, done, error, eng_req} == 4'b0, "R1", "in reset", 64'({busy, done, error, eng_req}), 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check({busy, done, error, eng_req} == 4'b0, "R1", "after reset", 64'({busy, done, error, eng_req}), 64'h0);

        // R10 chip erase before init: single lane everywhere, two busy reads
        busy_q.push_back(2);
        push_wren(2'd0);
        push(8'hC7, 2'd0, 2'd0, 1'b0, 24'h0, 9'd0, 5'd0);
        push_rdsr(2'd0); push_rdsr(2'd0); push_rdsr(2'd0);
        push_mmap(2'd0);
        run_op(2'd0, 24'h000123, 16'd0, 1'b0, 1'b0, "R10");

        // R6 init: lane switch on one lane, restore on four
        push(8'h38, 2'd0, 2'd0, 1'b0, 24'h0, 9'd0, 5'd0);
        push_mmap(2'd2);
        run_op(2'd3, 24'h0, 16'd0, 1'b0, 1'b0, "R6");

        // R8 sector erase with a start pulse mid-job
        busy_q.push_back(0);
        push_wren(2'd2);
        push(8'h20, 2'd2, 2'd0, 1'b1, 24'h012345, 9'd0, 5'd0);
        push_rdsr(2'd2);
        push_mmap(2'd2);
        run_op(2'd1, 24'h012345, 16'd0, 1'b0, 1'b1, "R8");

        // R5 unaligned program: 16 + 256 + 28 bytes
        busy_q.push_back(1); busy_q.push_back(1); busy_q.push_back(1);
        push_wren(2'd2); push(8'h02, 2'd2, 2'd0, 1'b1, 24'h0000F0, 9'd16,  5'd0); push_rdsr(2'd2); push_rdsr(2'd2);
        push_wren(2'd2); push(8'h02, 2'd2, 2'd0, 1'b1, 24'h000100, 9'd256, 5'd0); push_rdsr(2'd2); push_rdsr(2'd2);
        push_wren(2'd2); push(8'h02, 2'd2, 2'd0, 1'b1, 24'h000200, 9'd28,  5'd0); push_rdsr(2'd2); push_rdsr(2'd2);
        push_mmap(2'd2);
        run_op(2'd2, 24'h0000F0, 16'd300, 1'b0, 1'b0, "R5");

        // R5 aligned full page
        busy_q.push_back(0);
        push_wren(2'd2); push(8'h02, 2'd2, 2'd0, 1'b1, 24'h000300, 9'd256, 5'd0); push_rdsr(2'd2);
        push_mmap(2'd2);
        run_op(2'd2, 24'h000300, 16'd256, 1'b0, 1'b0, "R5");

        // R7 flash never leaves busy: POLL_MAX reads then restore with error
        busy_q.push_back(100);
        push_wren(2'd2);
        push(8'h C7, 2'd2, 2'd0, 1'b0, 24'h0, 9'd0, 5'd0);
        for (int i = 0; i < POLL_MAX; i++) push_rdsr(2'd2);
        push_mmap(2'd2);
        run_op(2'd0, 24'h0, 16'd0, 1'b1, 1'b0, "R7");

        // R5 zero-length program: only the restore, error cleared (R7)
        push_mmap(2'd2);
        run_op(2'd2, 24'h000040, 16'd0, 1'b0, 1'b0, "R5");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule